// File: doc/BRIEF.md
# Multiplexed LCD Backplane and Segment Level Sequencer

This block steps a multiplexed liquid-crystal panel through its time slots. For each slot it produces a digital level index for every backplane pin and every segment pin. Analog switches outside this block turn each index into a voltage tap. The display pattern comes from an 8-row by 60-column display register. The block reads that register live, one row per slot, using the row the current slot and the output bank setting point to.

Five multiplex ratios are available: static, 1:2, 1:4, 1:6 and 1:8. Three bias settings are available for the multiplexed ratios. The DC component across each pixel can be cancelled in either of two ways. In line inversion every row is shown in both polarities within one frame. In frame inversion consecutive frames alternate polarity. An external single-cycle `slot_tick` advances the sequence, so the frame rate is set entirely by how often the tick arrives. The ratio, bias, inversion and bank settings are sampled only at a frame boundary or while the display is disabled, so a reconfiguration never tears a frame.

Top module: `lcd_mux_sequencer`

## Requirements
- R1: While reset is asserted and after its release, every backplane and segment code is 0, `cur_row` is 0 and `cur_pol` is 0.
- R2: The clock edge after `disp_en` is seen low, every code becomes 0 and `cur_row` and `cur_pol` become 0. Ticks have no effect while disabled. The edge that first sees `disp_en` high starts phase 0 with the settings present at that edge, with frame polarity positive.
- R3: With `frame_inv`=0, a frame has 2N phases (N active backplanes). Phase p shows slot p/2 with polarity p mod 2 (0 positive, 1 negative), and each tick advances one phase.
- R4: With `frame_inv`=1, a frame has N phases. Phase p shows slot p, and the polarity stays fixed within the frame. A frame-polarity flag starts positive on enable and flips at every frame wrap. Wraps of line-inversion frames also flip it.
- R5: N follows `mux_mode`: 0 gives 1 (static), 1 gives 2, 2 gives 4, 3 gives 6, and 4 through 7 give 8.
- R6: Backplane b, for b < N, receives step D when b equals `cur_row` and step 1 otherwise. Backplanes b >= N receive code 0. Under negative polarity a step k becomes D-k. The code is the step plus 1, packed as 3 bits per pin with pin 0 in the low bits.
- R7: A segment whose pixel bit is 1 receives step 0. An off pixel receives step 1 in static mode and step 2 otherwise. Polarity and code mapping are the same as in R6. The bit for row r and segment s sits at `disp_row_data[r*60+s]`.
- R8: The divisor D is 1 in static mode. Otherwise `bias_sel` 0 gives D=2 (3 levels), 1 gives D=3 (4 levels), and 2 or 3 give D=4 (5 levels).
- R9: The display-register row read in a slot is chosen as follows. Static mode reads row `out_bank`. The 1:2 mode reads {`out_bank`[2:1], slot[0]}. The 1:4 mode reads {`out_bank`[2], slot[1:0]}. The 1:6 and 1:8 modes read the slot, and `out_bank` has no effect.
- R10: While enabled, changes to `mux_mode`, `bias_sel`, `frame_inv` or `out_bank` leave the outputs unchanged until the tick that wraps the frame. The new values are sampled at that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_tick | input | 1 | One-cycle enable advancing the sequence by one phase |
| mux_mode | input | 3 | Multiplex ratio select (R5) |
| bias_sel | input | 2 | Bias select for multiplexed ratios (R8) |
| frame_inv | input | 1 | 1 selects frame inversion, 0 selects line inversion |
| disp_en | input | 1 | Display enable; 0 forces idle codes |
| out_bank | input | 3 | Display bank selection (R9) |
| disp_row_data | input | 480 | Display register, 8 rows of 60 pixel bits |
| bp_code | output | 24 | Backplane level codes, 3 bits per pin |
| seg_code | output | 180 | Segment level codes, 3 bits per pin |
| cur_row | output | 3 | Active backplane slot |
| cur_pol | output | 1 | Current drive polarity, 1 negative |

## Verification
The assertions assume that `slot_tick` is a clean single-cycle strobe and that all settings are known values, never X. They also assume that settings may change at any cycle, including in the middle of a frame, because the block must absorb such changes itself. The stimulus drives every input on the falling clock edge and pulses the tick for exactly one cycle. On purpose, it changes settings only in the middle of frames and at cycles with no tick, so that the boundary sampling of R10 is exercised. Every mode code, including the alias codes 5 to 7 and bias code 3, is driven at least once.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

  localparam int ROW_CNT = 8;
  localparam int ROW_W   = $clog2(ROW_CNT);
  localparam int PHASE_W = ROW_W + 1;
  localparam int CODE_W  = 3;
  localparam int STEP_W  = 3;

  typedef struct packed {
    logic [2:0] mode;
    logic [1:0] bias;
    logic       frame_inv;
    logic [2:0] bank;
  } drive_cfg_t;

  // active backplane count for a ratio code
  function automatic logic [ROW_W:0] rows_for_mode(input logic [2:0] m);
    case (m)
      3'd0:    return (ROW_W+1)'(1);
      3'd1:    return (ROW_W+1)'(2);
      3'd2:    return (ROW_W+1)'(4);
      3'd3:    return (ROW_W+1)'(6);
      default: return (ROW_W+1)'(8);
    endcase
  endfunction

  // number of voltage steps between the rails
  function automatic logic [STEP_W-1:0] bias_div(input logic [2:0] m,
                                                 input logic [1:0] b);
    if (m == 3'd0)      return STEP_W'(1);
    else if (b == 2'd0) return STEP_W'(2);
    else if (b == 2'd1) return STEP_W'(3);
    else                return STEP_W'(4);
  endfunction

  // display-register row for a slot, honouring the bank split
  function automatic logic [ROW_W-1:0] bank_row(input logic [2:0]       m,
                                                input logic [2:0]       bank,
                                                input logic [ROW_W-1:0] slot);
    case (m)
      3'd0:    return bank;
      3'd1:    return {bank[2:1], slot[0]};
      3'd2:    return {bank[2], slot[1:0]};
      default: return slot;
    endcase
  endfunction

  // mirror a step for negative polarity, then shift past the idle code
  function automatic logic [CODE_W-1:0] level_code(input logic [STEP_W-1:0] step,
                                                   input logic [STEP_W-1:0] div,
                                                   input logic              neg);
    logic [STEP_W-1:0] v;
    v = neg ? (div - step) : step;
    return CODE_W'(v + STEP_W'(1));
  endfunction

endpackage

// File: rtl/lcdseq_timing.sv
module lcdseq_timing
  import lcdseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_tick,
  input  logic             disp_en,
  input  drive_cfg_t       cfg_in,
  output logic             en_q,
  output drive_cfg_t       cfg_q,
  output logic             frame_last,
  output logic [ROW_W:0]   nrows,
  output logic [ROW_W-1:0] cur_slot,
  output logic             cur_pol
);

  logic [PHASE_W-1:0] phase_q, phase_d;
  logic               fpol_q, fpol_d;
  logic               en_d;
  drive_cfg_t         cfg_d;
  logic [PHASE_W:0]   span;
  logic [PHASE_W:0]   last_ph;

  // frame length: N phases in frame inversion, 2N in line inversion
  always_comb begin
    nrows      = rows_for_mode(cfg_q.mode);
    span       = cfg_q.frame_inv ? {1'b0, nrows} : {nrows, 1'b0};
    last_ph    = span - (PHASE_W+1)'(1);
    frame_last = (phase_q == last_ph[PHASE_W-1:0]);
  end

  always_comb begin
    cur_slot = cfg_q.frame_inv ? phase_q[ROW_W-1:0] : phase_q[PHASE_W-1:1];
    cur_pol  = cfg_q.frame_inv ? fpol_q : phase_q[0];
  end

  // next state
  always_comb begin
    en_d    = disp_en;
    phase_d = phase_q;
    fpol_d  = fpol_q;
    cfg_d   = cfg_q;
    if (!en_q) begin
      phase_d = '0;
      fpol_d  = 1'b0;
      cfg_d   = cfg_in;
    end else if (slot_tick) begin
      if (frame_last) begin
        phase_d = '0;
        fpol_d  = ~fpol_q;
        cfg_d   = cfg_in;
      end else begin
        phase_d = phase_q + PHASE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      phase_q <= '0;
      fpol_q  <= 1'b0;
      cfg_q   <= '0;
    end else begin
      en_q    <= en_d;
      phase_q <= phase_d;
      fpol_q  <= fpol_d;
      cfg_q   <= cfg_d;
    end
  end

endmodule

// File: rtl/lcdseq_bp_drv.sv
module lcdseq_bp_drv
  import lcdseq_pkg::*;
#(
  parameter int NUM_BP = 8
) (
  input  logic                     en,
  input  logic [ROW_W-1:0]         slot,
  input  logic [ROW_W:0]           nrows,
  input  logic [STEP_W-1:0]        div,
  input  logic                     pol,
  output logic [NUM_BP*CODE_W-1:0] bp_code,
  output logic [NUM_BP-1:0]        bp_sel
);

  for (genvar b = 0; b < NUM_BP; b++) begin : g_bp
    localparam logic [ROW_W:0] IDX = (ROW_W+1)'(b);
    logic used;
    assign used      = (IDX < nrows);
    assign bp_sel[b] = en && used && (slot == IDX[ROW_W-1:0]);
    assign bp_code[b*CODE_W +: CODE_W] =
      (en && used) ? level_code(bp_sel[b] ? div : STEP_W'(1), div, pol)
                   : '0;
  end

endmodule

// File: rtl/lcdseq_seg_drv.sv
module lcdseq_seg_drv
  import lcdseq_pkg::*;
#(
  parameter int NUM_SEG = 60,
  parameter int ROWS    = 8
) (
  input  logic                      en,
  input  logic [ROW_W-1:0]          mem_row,
  input  logic [STEP_W-1:0]         div,
  input  logic                      pol,
  input  logic                      is_static,
  input  logic [ROWS*NUM_SEG-1:0]   row_data,
  output logic [NUM_SEG*CODE_W-1:0] seg_code
);

  logic [NUM_SEG-1:0] row_bits [ROWS];
  logic [NUM_SEG-1:0] cur_bits;
  logic [STEP_W-1:0]  off_step;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_bits[r] = row_data[r*NUM_SEG +: NUM_SEG];
  end

  assign cur_bits = row_bits[mem_row];
  assign off_step = is_static ? STEP_W'(1) : STEP_W'(2);

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    assign seg_code[s*CODE_W +: CODE_W] =
      en ? level_code(cur_bits[s] ? STEP_W'(0) : off_step, div, pol) : '0;
  end

endmodule

// File: rtl/lcd_mux_sequencer.sv
module lcd_mux_sequencer
  import lcdseq_pkg::*;
#(
  parameter int NUM_SEG = 60,
  parameter int NUM_BP  = lcdseq_pkg::ROW_CNT
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         slot_tick,
  input  logic [2:0]                   mux_mode,
  input  logic [1:0]                   bias_sel,
  input  logic                         frame_inv,
  input  logic                         disp_en,
  input  logic [2:0]                   out_bank,
  input  logic [NUM_BP*NUM_SEG-1:0]    disp_row_data,
  output logic [NUM_BP*CODE_W-1:0]     bp_code,
  output logic [NUM_SEG*CODE_W-1:0]    seg_code,
  output logic [ROW_W-1:0]             cur_row,
  output logic                         cur_pol
);

  drive_cfg_t        cfg_in, cfg_q;
  logic              en_q, frame_last;
  logic [ROW_W:0]    nrows;
  logic [ROW_W-1:0]  slot;
  logic              pol;
  logic [STEP_W-1:0] div;
  logic [ROW_W-1:0]  mem_row;
  logic [NUM_BP-1:0] bp_sel;

  always_comb begin
    cfg_in.mode      = mux_mode;
    cfg_in.bias      = bias_sel;
    cfg_in.frame_inv = frame_inv;
    cfg_in.bank      = out_bank;
  end

  lcdseq_timing u_timing (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_tick  (slot_tick),
    .disp_en    (disp_en),
    .cfg_in     (cfg_in),
    .en_q       (en_q),
    .cfg_q      (cfg_q),
    .frame_last (frame_last),
    .nrows      (nrows),
    .cur_slot   (slot),
    .cur_pol    (pol)
  );

  assign div     = bias_div(cfg_q.mode, cfg_q.bias);
  assign mem_row = bank_row(cfg_q.mode, cfg_q.bank, slot);

  lcdseq_bp_drv #(.NUM_BP(NUM_BP)) u_bp (
    .en      (en_q),
    .slot    (slot),
    .nrows   (nrows),
    .div     (div),
    .pol     (pol),
    .bp_code (bp_code),
    .bp_sel  (bp_sel)
  );

  lcdseq_seg_drv #(.NUM_SEG(NUM_SEG), .ROWS(NUM_BP)) u_seg (
    .en        (en_q),
    .mem_row   (mem_row),
    .div       (div),
    .pol       (pol),
    .is_static (cfg_q.mode == 3'd0),
    .row_data  (disp_row_data),
    .seg_code  (seg_code)
  );

  assign cur_row = slot;
  assign cur_pol = pol;

endmodule

// File: rtl/lcdseq_checker.sv
module lcdseq_checker
  import lcdseq_pkg::*;
#(
  parameter int NUM_SEG = 60,
  parameter int NUM_BP  = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      slot_tick,
  input logic                      en_q,
  input drive_cfg_t                cfg_q,
  input logic                      frame_last,
  input logic [NUM_BP-1:0]         bp_sel,
  input logic [NUM_BP*CODE_W-1:0]  bp_code,
  input logic [NUM_SEG*CODE_W-1:0] seg_code,
  input logic                      cur_pol
);

  // R2: disabled display carries only idle codes
  a_r2_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (bp_code == '0 && seg_code == '0));

  // R6: exactly one backplane is selected while running
  a_r6_single_active: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> ($countones(bp_sel) == 1));

  // R6: static mode leaves backplanes 1 and up idle
  a_r6_unused_bp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cfg_q.mode == 3'd0) |-> (bp_code[NUM_BP*CODE_W-1:CODE_W] == '0));

  // R3: line inversion flips polarity on every tick inside a frame
  a_r3_line_pol_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && slot_tick && !cfg_q.frame_inv && !frame_last) |=> (cur_pol != $past(cur_pol)));

  // R4: frame inversion holds polarity inside a frame
  a_r4_frame_pol_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && slot_tick && cfg_q.frame_inv && !frame_last) |=> $stable(cur_pol));

  // R10: settings only move at a wrapping tick
  a_r10_cfg_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !(slot_tick && frame_last)) |=> $stable(cfg_q));

endmodule

bind lcd_mux_sequencer lcdseq_checker #(.NUM_SEG(NUM_SEG), .NUM_BP(NUM_BP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slot_tick  (slot_tick),
  .en_q       (en_q),
  .cfg_q      (cfg_q),
  .frame_last (frame_last),
  .bp_sel     (bp_sel),
  .bp_code    (bp_code),
  .seg_code   (seg_code),
  .cur_pol    (cur_pol)
);

// File: tb/lcd_mux_sequencer_test.sv
`timescale 1ns/1ps
module lcd_mux_sequencer_test;

  localparam int NSEG = 60;
  localparam int NBP  = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                 rst_n, slot_tick, frame_inv, disp_en;
  logic [2:0]           mux_mode, out_bank;
  logic [1:0]           bias_sel;
  logic [NBP*NSEG-1:0]  dr;
  logic [NBP*3-1:0]     bp_code;
  logic [NSEG*3-1:0]    seg_code;
  logic [2:0]           cur_row;
  logic                 cur_pol;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  int m_en, ph, fp, mc_mode, mc_bias, mc_inv, mc_bank;

  lcd_mux_sequencer uut (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .mux_mode(mux_mode),
    .bias_sel(bias_sel), .frame_inv(frame_inv), .disp_en(disp_en),
    .out_bank(out_bank), .disp_row_data(dr), .bp_code(bp_code),
    .seg_code(seg_code), .cur_row(cur_row), .cur_pol(cur_pol)
  );

  function automatic int rows_of(int m);
    case (m)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 6;
      default: return 8;
    endcase
  endfunction

  function automatic int div_of(int m, int b);
    if (m == 0) return 1;
    if (b == 0) return 2;
    if (b == 1) return 3;
    return 4;
  endfunction

  function automatic int mem_of(int m, int bank, int slot);
    case (m)
      0: return bank;
      1: return (bank & 6) | (slot & 1);
      2: return (bank & 4) | (slot & 3);
      default: return slot;
    endcase
  endfunction

  function automatic int code_of(int step, int d, int neg);
    return (neg != 0 ? d - step : step) + 1;
  endfunction

  task automatic chk_int(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_vec(string req, string what, logic [NSEG*3-1:0] act,
                         logic [NSEG*3-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load_cfg();
    mc_mode = mux_mode; mc_bias = bias_sel; mc_inv = frame_inv; mc_bank = out_bank;
  endtask

  // compare every output against the model
  task automatic check_now(string ctx);
    logic [NSEG*3-1:0] e_bp, e_seg;
    int slot, pol, n, d, mr, stp;
    string rq_t, rq_b, rq_s;
    #1;
    e_bp = '0; e_seg = '0; slot = 0; pol = 0;
    rq_t = "R2"; rq_b = "R2"; rq_s = "R2";
    if (m_en != 0) begin
      n = rows_of(mc_mode);
      d = div_of(mc_mode, mc_bias);
      if (mc_inv != 0) begin slot = ph; pol = fp; rq_t = "R4"; end
      else begin slot = ph / 2; pol = ph % 2; rq_t = "R3"; end
      rq_b = "R6"; rq_s = "R7";
      for (int b = 0; b < NBP; b++) begin
        if (b < n) begin
          stp = (b == slot) ? d : 1;
          e_bp[b*3 +: 3] = 3'(code_of(stp, d, pol));
        end
      end
      mr = mem_of(mc_mode, mc_bank, slot);
      for (int s = 0; s < NSEG; s++) begin
        stp = dr[mr*NSEG + s] ? 0 : (mc_mode == 0 ? 1 : 2);
        e_seg[s*3 +: 3] = 3'(code_of(stp, d, pol));
      end
    end
    chk_int(rq_t, {ctx, " cur_row"}, int'(cur_row), slot);
    chk_int(rq_t, {ctx, " cur_pol"}, int'(cur_pol), pol);
    chk_vec(rq_b, {ctx, " bp_code"}, {{(NSEG-NBP)*3{1'b0}}, bp_code}, e_bp);
    chk_vec(rq_s, {ctx, " seg_code"}, seg_code, e_seg);
  endtask

  task automatic do_tick();
    int last;
    @(negedge clk) slot_tick = 1'b1;
    @(negedge clk) slot_tick = 1'b0;
    if (m_en != 0) begin
      last = (mc_inv != 0) ? rows_of(mc_mode) - 1 : 2*rows_of(mc_mode) - 1;
      if (ph == last) begin ph = 0; fp ^= 1; load_cfg(); end
      else ph++;
    end
  endtask

  task automatic enable_dut();
    @(negedge clk) disp_en = 1'b1;
    @(negedge clk);
    m_en = 1; ph = 0; fp = 0; load_cfg();
  endtask

  task automatic disable_dut();
    @(negedge clk) disp_en = 1'b0;
    @(negedge clk);
    m_en = 0; ph = 0; fp = 0;
  endtask

  task automatic set_cfg(int m, int b, int inv, int bank);
    mux_mode = 3'(m); bias_sel = 2'(b); frame_inv = 1'(inv); out_bank = 3'(bank);
  endtask

  task automatic set_pattern(int seed);
    for (int r = 0; r < NBP; r++)
      for (int s = 0; s < NSEG; s++)
        dr[r*NSEG + s] = (((r*7 + s*5 + seed) % 3) == 0);
  endtask

  task automatic run_ticks(string ctx, int cnt);
    for (int i = 0; i < cnt; i++) begin
      do_tick();
      check_now(ctx);
    end
  endtask

  // R1
  task automatic test_reset();
    #1;
    chk_int("R1", "bp_code in reset", int'(bp_code != '0), 0);
    chk_int("R1", "seg_code in reset", int'(seg_code != '0), 0);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk_int("R1", "bp_code after reset", int'(bp_code != '0), 0);
    chk_int("R1", "seg_code after reset", int'(seg_code != '0), 0);
    chk_int("R1", "cur_row after reset", int'(cur_row), 0);
    chk_int("R1", "cur_pol after reset", int'(cur_pol), 0);
  endtask

  // R2: ticks while disabled do nothing
  task automatic test_disabled();
    set_cfg(2, 1, 0, 0);
    run_ticks("R2 disabled", 5);
  endtask

  // R3 R5 R6 R7 R8: line inversion at 1:4, bias 1/3, two frames
  task automatic test_line_mux4();
    set_cfg(2, 1, 0, 0);
    enable_dut();
    check_now("R3 line mux4 start");
    run_ticks("R3 line mux4", 16);
    set_pattern(2);
    check_now("R7 new pattern");
    disable_dut();
    check_now("R2 after disable");
  endtask

  // R4 R8: frame inversion at 1:8, bias 1/4, three frames
  task automatic test_frame_mux8();
    set_cfg(4, 2, 1, 0);
    enable_dut();
    check_now("R4 frame mux8 start");
    run_ticks("R4 frame mux8", 24);
    disable_dut();
  endtask

  // R9 R10: static drive from bank 5, then switch inversion mid-frame
  task automatic test_static();
    set_cfg(0, 2, 0, 5);
    enable_dut();
    check_now("R9 static bank5");
    run_ticks("R9 static line", 3);
    @(negedge clk) set_cfg(0, 2, 1, 3);
    check_now("R10 static pending");
    run_ticks("R10 static frame", 5);
    disable_dut();
  endtask

  // R5 R8 R9: bank mapping and alias codes
  task automatic test_banks();
    set_cfg(1, 0, 0, 6);
    enable_dut();
    run_ticks("R9 mux2 bank6", 4);
    disable_dut();
    set_cfg(2, 3, 1, 4);
    enable_dut();
    run_ticks("R9 mux4 bank4 bias3", 8);
    disable_dut();
    set_cfg(3, 1, 0, 3);
    enable_dut();
    run_ticks("R9 mux6 bank ignored", 12);
    disable_dut();
    set_cfg(7, 0, 1, 7);
    enable_dut();
    run_ticks("R5 mode7 as mux8", 9);
    disable_dut();
  endtask

  // R10: reconfigure inside a frame; old settings stay until wrap
  task automatic test_midframe();
    set_cfg(4, 1, 0, 0);
    enable_dut();
    run_ticks("R10 mux8 line", 3);
    @(negedge clk) set_cfg(1, 0, 1, 2);
    check_now("R10 held no tick");
    run_ticks("R10 until wrap", 13);
    run_ticks("R10 new mux2 frame", 5);
    disable_dut();
  endtask

  initial begin
    rst_n = 1'b0; slot_tick = 1'b0; disp_en = 1'b0;
    set_cfg(0, 0, 0, 0);
    set_pattern(0);
    m_en = 0; ph = 0; fp = 0; load_cfg();
    repeat (3) @(negedge clk);
    test_reset();
    test_disabled();
    test_line_mux4();
    test_frame_mux8();
    test_static();
    test_banks();
    test_midframe();
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual run still busy, expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule